// File: doc/BRIEF.md
# Multicycle Accumulator Processor Sequencer

This block is a small processor built around one accumulator. Instructions and data sit in the same single-port synchronous memory, and one address bus and one data path serve both instruction fetch and operand access. Each instruction runs as a fixed series of register transfers, one transfer per state:

- **Fetch:** the program counter goes to the memory address register, the memory word lands in the memory data register, and that value moves into the current instruction register.
- **Decode:** the current instruction is decoded.
- **Execute:** the operand address goes to the memory address register, the operand word is read, and the accumulator is updated.

The memory needs one cycle to return read data. For that reason every read is followed by a wait state before the memory data register captures the word. The internal registers are brought out on debug ports so that a test environment or a trace unit can follow every transfer. A halt output rises when the program executes its halt instruction.

Top module: `acc_cpu_top`

## Requirements
- R1: While reset is active, PC, MAR, MDR, CIR and ACC read zero, halt is low and mem_we is low. Reset acts asynchronously. After release, fetching starts at address 0.
- R2: mem_addr always equals the MAR value. An instruction reaches CIR only through MAR (loaded from PC) and MDR (loaded from mem_rdata). After a run, CIR holds the last instruction fetched.
- R3: PC increments by exactly one per instruction fetch and changes in no other way.
- R4: An instruction is DATA_W bits wide. The upper 4 bits are the opcode and the lower bits are the operand memory address.
- R5: Opcode 0001 (load) copies the addressed word into ACC.
- R6: Opcode 0010 (add) sets ACC to ACC plus the addressed word, modulo 2^DATA_W.
- R7: Opcode 0011 (subtract) sets ACC to ACC minus the addressed word, modulo 2^DATA_W. Opcode 0100 (and) sets ACC to the bitwise AND of ACC and the addressed word.
- R8: Opcode 0101 (store) writes ACC to the operand address through MDR, with mem_we high for exactly one cycle. ACC does not change.
- R9: Opcodes 0110 to 1111 are no-ops. They complete the fetch and decode, leave ACC and memory unchanged, and let execution continue at the next address.
- R10: Opcode 0000 (halt) raises halt. Halt then stays high until reset. After that, no write occurs and PC, MAR and ACC hold their values.
- R11: Each memory read spends a wait cycle before MDR captures the word. The resulting instruction lengths are:
  - 9 cycles for load, add, subtract and and;
  - 8 cycles for store;
  - 5 cycles for a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously |
| mem_addr | output | DATA_W-4 | Memory address, driven from MAR |
| mem_wdata | output | DATA_W | Write data, driven from MDR |
| mem_we | output | 1 | Write enable, high for one cycle per store |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the address |
| halt | output | 1 | High once a halt instruction has executed |
| dbg_pc | output | DATA_W-4 | Program counter |
| dbg_mar | output | DATA_W-4 | Memory address register |
| dbg_mdr | output | DATA_W | Memory data register |
| dbg_cir | output | DATA_W | Current instruction register |
| dbg_acc | output | DATA_W | Accumulator |

## Verification
A short fixed program is run for each operation:

- a load of the first operand;
- the operation under test on the second operand;
- a store of the result;
- a halt.

The operand pairs are chosen to tell the operations apart. An add that wraps past 255 separates modular addition from saturating addition. A subtraction with a smaller minuend checks the borrow wrap. AND operands with partial overlap give a result distinct from OR and from either input. Load-over-load shows that the second word replaces the first. Two unused opcodes must leave the first operand intact.

A separate mixed program measures the spacing between program counter steps. This tells apart the read-with-wait path, the store path and the no-op path. A reset applied in the middle of a run checks that the asynchronous clear works.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_HALT  = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_AND   = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'b0101;

  typedef enum logic [3:0] {
    S_FMAR, S_FWAIT, S_FMDR, S_FCIR, S_DEC,
    S_XMAR, S_XWAIT, S_XMDR, S_XEXE, S_XST, S_XWR, S_HALT
  } cpu_state_e;

  typedef enum logic [1:0] {
    ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND
  } alu_fn_e;
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opd_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (fn_i)
      ALU_ADD: res_o = acc_i + opd_i;
      ALU_SUB: res_o = acc_i - opd_i;
      ALU_AND: res_o = acc_i & opd_i;
      default: res_o = opd_i;
    endcase
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             pc_to_mar_o,
  output logic             opd_to_mar_o,
  output logic             pc_inc_o,
  output logic             mem_to_mdr_o,
  output logic             acc_to_mdr_o,
  output logic             mdr_to_cir_o,
  output logic             acc_load_o,
  output alu_fn_e          alu_fn_o,
  output logic             mem_we_o,
  output logic             halt_o
);
  cpu_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_FMAR:  st_d = S_FWAIT;
      S_FWAIT: st_d = S_FMDR;
      S_FMDR:  st_d = S_FCIR;
      S_FCIR:  st_d = S_DEC;
      S_DEC: begin
        case (opcode_i)
          OPC_HALT:                                        st_d = S_HALT;
          OPC_LOAD, OPC_ADD, OPC_SUB, OPC_AND, OPC_STORE:  st_d = S_XMAR;
          default:                                         st_d = S_FMAR;
        endcase
      end
      S_XMAR:  st_d = (opcode_i == OPC_STORE) ? S_XST : S_XWAIT;
      S_XWAIT: st_d = S_XMDR;
      S_XMDR:  st_d = S_XEXE;
      S_XEXE:  st_d = S_FMAR;
      S_XST:   st_d = S_XWR;
      S_XWR:   st_d = S_FMAR;
      S_HALT:  st_d = S_HALT;
      default: st_d = S_FMAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_FMAR;
    else        st_q <= st_d;
  end

  always_comb begin
    pc_to_mar_o  = (st_q == S_FMAR);
    pc_inc_o     = (st_q == S_FWAIT);
    mem_to_mdr_o = (st_q == S_FMDR) || (st_q == S_XMDR);
    mdr_to_cir_o = (st_q == S_FCIR);
    opd_to_mar_o = (st_q == S_XMAR);
    acc_to_mdr_o = (st_q == S_XST);
    mem_we_o     = (st_q == S_XWR);
    acc_load_o   = (st_q == S_XEXE);
    halt_o       = (st_q == S_HALT);
    case (opcode_i)
      OPC_ADD: alu_fn_o = ALU_ADD;
      OPC_SUB: alu_fn_o = ALU_SUB;
      OPC_AND: alu_fn_o = ALU_AND;
      default: alu_fn_o = ALU_PASS;
    endcase
  end

  // R8: a store write lasts a single cycle
  assert_we_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);
  // R10: halt is sticky and never coincides with a write
  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o);
  assert_halt_no_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !mem_we_o);
endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_to_mar_i,
  input  logic              opd_to_mar_i,
  input  logic              pc_inc_i,
  input  logic              mem_to_mdr_i,
  input  logic              acc_to_mdr_i,
  input  logic              mdr_to_cir_i,
  input  logic              acc_load_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] alu_res_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic [DATA_W-1:0] cir_o,
  output logic [DATA_W-1:0] acc_o
);
  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [DATA_W-1:0] mdr_q, mdr_d, cir_q, cir_d, acc_q, acc_d;

  always_comb begin
    pc_d  = pc_inc_i ? pc_q + 1'b1 : pc_q;
    mar_d = mar_q;
    if (pc_to_mar_i)       mar_d = pc_q;
    else if (opd_to_mar_i) mar_d = cir_q[ADDR_W-1:0];
    mdr_d = mdr_q;
    if (mem_to_mdr_i)      mdr_d = mem_rdata_i;
    else if (acc_to_mdr_i) mdr_d = acc_q;
    cir_d = mdr_to_cir_i ? mdr_q : cir_q;
    acc_d = acc_load_i ? alu_res_i : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      cir_q <= '0;
      acc_q <= '0;
    end else begin
      pc_q  <= pc_d;
      mar_q <= mar_d;
      mdr_q <= mdr_d;
      cir_q <= cir_d;
      acc_q <= acc_d;
    end
  end

  assign pc_o  = pc_q;
  assign mar_o = mar_q;
  assign mdr_o = mdr_q;
  assign cir_o = cir_q;
  assign acc_o = acc_q;

  // R3: the program counter only ever steps by one
  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc_q) |-> pc_q == $past(pc_q) + 1'b1);
  // R2: the instruction register is fed from the data register
  assert_cir_from_mdr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cir_q) |-> cir_q == $past(mdr_q));
endmodule

// File: rtl/acc_cpu_top.sv
module acc_cpu_top
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halt,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [ADDR_W-1:0] dbg_mar,
  output logic [DATA_W-1:0] dbg_mdr,
  output logic [DATA_W-1:0] dbg_cir,
  output logic [DATA_W-1:0] dbg_acc
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic    pc_to_mar, opd_to_mar, pc_inc, mem_to_mdr, acc_to_mdr, mdr_to_cir, acc_load;
  alu_fn_e alu_fn;
  logic [DATA_W-1:0] alu_res;

  acc_cpu_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .opcode_i    (dbg_cir[DATA_W-1 -: OPC_W]),
    .pc_to_mar_o (pc_to_mar),
    .opd_to_mar_o(opd_to_mar),
    .pc_inc_o    (pc_inc),
    .mem_to_mdr_o(mem_to_mdr),
    .acc_to_mdr_o(acc_to_mdr),
    .mdr_to_cir_o(mdr_to_cir),
    .acc_load_o  (acc_load),
    .alu_fn_o    (alu_fn),
    .mem_we_o    (mem_we),
    .halt_o      (halt)
  );

  acc_cpu_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .pc_to_mar_i (pc_to_mar),
    .opd_to_mar_i(opd_to_mar),
    .pc_inc_i    (pc_inc),
    .mem_to_mdr_i(mem_to_mdr),
    .acc_to_mdr_i(acc_to_mdr),
    .mdr_to_cir_i(mdr_to_cir),
    .acc_load_i  (acc_load),
    .mem_rdata_i (mem_rdata),
    .alu_res_i   (alu_res),
    .pc_o        (dbg_pc),
    .mar_o       (dbg_mar),
    .mdr_o       (dbg_mdr),
    .cir_o       (dbg_cir),
    .acc_o       (dbg_acc)
  );

  acc_cpu_alu #(.W(DATA_W)) u_alu (
    .acc_i(dbg_acc),
    .opd_i(dbg_mdr),
    .fn_i (alu_fn),
    .res_o(alu_res)
  );

  assign mem_addr  = dbg_mar;
  assign mem_wdata = dbg_mdr;

  // R10: accumulator and address freeze once halted
  assert_acc_frozen_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    halt |=> $stable(dbg_acc) && $stable(mem_addr));
  // R8: a store leaves the accumulator unchanged
  assert_store_keeps_acc_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_we |-> $stable(dbg_acc));
endmodule

// File: tb/sim_acc_cpu_top.sv
module sim_acc_cpu_top;
  localparam int DW = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] mem_addr, dbg_pc, dbg_mar;
  logic [DW-1:0] mem_wdata, mem_rdata, dbg_mdr, dbg_cir, dbg_acc;
  logic          mem_we, halt;

  logic [DW-1:0] mem [16];

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  acc_cpu_top #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halt(halt), .dbg_pc(dbg_pc),
    .dbg_mar(dbg_mar), .dbg_mdr(dbg_mdr), .dbg_cir(dbg_cir), .dbg_acc(dbg_acc)
  );

  // memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_res(input logic [3:0] op, input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
    case (op)
      4'h1:    return b;
      4'h2:    return a + b;
      4'h3:    return a - b;
      4'h4:    return a & b;
      default: return a;
    endcase
  endfunction

  // {opcode, first operand, second operand}
  localparam int NV = 7;
  localparam logic [19:0] VEC [NV] = '{
    {4'h2, 8'd25,  8'd12},
    {4'h2, 8'd200, 8'd100},
    {4'h3, 8'd5,   8'd9},
    {4'h4, 8'hF0,  8'h3C},
    {4'h1, 8'h11,  8'h77},
    {4'h9, 8'h5A,  8'hC3},
    {4'hF, 8'h81,  8'h01}
  };

  int iv [8];
  int n_iv, we_cnt;
  bit we_long, addr_bad, done;

  task automatic clear_mem();
    for (int i = 0; i < 16; i++) mem[i] = 8'hEE;
  endtask

  task automatic run_prog();
    int cyc = 0, last = -1;
    logic [AW-1:0] ppc;
    bit pwe = 0;
    n_iv = 0; we_cnt = 0; we_long = 0; addr_bad = 0; done = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    ppc = dbg_pc;
    rst_n = 1'b1;
    for (int i = 0; i < 3000 && !done; i++) begin
      @(negedge clk);
      cyc++;
      if (mem_addr !== dbg_mar) addr_bad = 1;
      if (mem_we) begin
        we_cnt++;
        if (pwe) we_long = 1;
      end
      pwe = mem_we;
      if (dbg_pc !== ppc) begin
        if (last >= 0 && n_iv < 8) begin
          iv[n_iv] = cyc - last;
          n_iv++;
        end
        last = cyc;
        ppc = dbg_pc;
      end
      if (halt) done = 1;
    end
    chk("R10 halt reached", {31'd0, done}, 32'd1);
  endtask

  initial begin : main
    rst_n = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pc",   dbg_pc,  0);
    chk("R1 mar",  dbg_mar, 0);
    chk("R1 mdr",  dbg_mdr, 0);
    chk("R1 cir",  dbg_cir, 0);
    chk("R1 acc",  dbg_acc, 0);
    chk("R1 halt", halt,    0);
    chk("R1 we",   mem_we,  0);

    // table walk: LOAD 14; <op> 15; STORE 13; HALT (R4 encoding: opcode in upper nibble)
    for (int k = 0; k < NV; k++) begin
      logic [3:0]    op;
      logic [DW-1:0] a, b, e;
      op = VEC[k][19:16];
      a  = VEC[k][15:8];
      b  = VEC[k][7:0];
      e  = ref_res(op, a, b);
      clear_mem();
      mem[0] = 8'h1E; mem[1] = {op, 4'hF}; mem[2] = 8'h5D; mem[3] = 8'h00;
      mem[14] = a; mem[15] = b;
      run_prog();
      // R5 R6 R7 R9: accumulator result
      chk($sformatf("R5/R6/R7/R9 acc op %0h", op), dbg_acc, e);
      // R8: stored word
      chk("R8 stored word", mem[13], e);
      chk("R8 single write", we_cnt, 1);
      chk("R9 operand untouched", mem[15], b);
      chk("R3 pc after halt", dbg_pc, 4);
    end

    // directed: timing, encoding, halt freeze, async reset
    clear_mem();
    mem[0] = 8'h1C; mem[1] = 8'h2D; mem[2] = 8'h5E; mem[3] = 8'h73; mem[4] = 8'h0B;
    mem[12] = 8'd25; mem[13] = 8'd12;
    run_prog();
    chk("R6 example sum", dbg_acc, 37);
    chk("R8 example store", mem[14], 37);
    chk("R8 write one cycle", {31'd0, we_long}, 0);
    chk("R2 address from mar", {31'd0, addr_bad}, 0);
    chk("R2 cir holds halt word", dbg_cir, 8'h0B);
    chk("R3 pc steps", dbg_pc, 5);
    chk("R11 interval count", n_iv, 4);
    chk("R11 load length", iv[0], 9);
    chk("R11 add length", iv[1], 9);
    chk("R11 store length", iv[2], 8);
    chk("R9 noop length", iv[3], 5);
    begin
      logic [AW-1:0] hpc, hmar;
      logic [DW-1:0] hacc;
      bit wr = 0, drop = 0;
      hpc = dbg_pc; hmar = dbg_mar; hacc = dbg_acc;
      repeat (20) begin
        @(negedge clk);
        if (mem_we) wr = 1;
        if (!halt) drop = 1;
      end
      chk("R10 no write after halt", {31'd0, wr}, 0);
      chk("R10 halt stays high", {31'd0, drop}, 0);
      chk("R10 pc frozen", dbg_pc, hpc);
      chk("R10 mar frozen", dbg_mar, hmar);
      chk("R10 acc frozen", dbg_acc, hacc);
    end
    // R1: asynchronous reset in the middle of a run
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async pc",   dbg_pc,  0);
    chk("R1 async acc",  dbg_acc, 0);
    chk("R1 async cir",  dbg_cir, 0);
    chk("R1 async halt", halt,    0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 8);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule